// File: doc/BRIEF.md
# Averaging Phase Select Sequencer

This block drives the feedback-phase selection of a multiphase clock generator. A 7-bit control word is split into a 5-bit base phase index n and a 2-bit averaging offset k. The block repeats a four-cycle frame, one slot per reference-clock cycle. In each slot it passes on either n or the next phase n+1, so the loop filter downstream settles on the average of the two and reaches quarter-phase resolution without analog interpolation.

The chosen 5-bit code is registered and then split into the controls for the analog path. The top three bits are coarse: two are multiplexer selects and one swaps the polarity of the differential pair. The bottom two bits are fine and become a 4-bit thermometer code for a current-mode interpolator. One input bypasses averaging so that n is passed on in every slot. A second input turns the fine thermometer output off. A control word is accepted only at a frame boundary, so a frame always carries one complete pattern.

Top module: `phase_avg_seq`

## Requirements
- R1: A synchronous active-high reset clears the frame position, the held control word and all outputs to zero. The first clock edge after reset is released is a frame-start edge.
- R2: The control word and the bypass input are sampled only on frame-start edges, which are every fourth edge. Changes between those edges have no effect on the outputs for the rest of the current pattern.
- R3: With offset k = 0 (phase_code[1:0]), the four slots of a frame all give n, where n = phase_code[6:2].
- R4: With k = 1, the slots give n, n, n, n+1 in that order.
- R5: With k = 2, the slots give n, n+1, n, n+1.
- R6: With k = 3, the slots give n, n+1, n+1, n+1.
- R7: n+1 is taken modulo 32, so base 31 steps to 0.
- R8: When avg_bypass is high on a frame-start edge, every slot of that frame gives n, whatever k is.
- R9: mux_sel equals pick_code[3:2] and flip equals pick_code[4], on the same cycle as pick_code.
- R10: With fine_en high, fine_therm bit i is 1 exactly when i < pick_code[1:0]. This gives 0000, 0001, 0011 and 0111 for fine values 0 to 3.
- R11: fine_en is taken on every edge. When it was low at an edge, fine_therm is 0000 after that edge.
- R12: A word sampled on frame-start edge 4m appears on pick_code after edges 4m+1 through 4m+4, one slot per edge. Before edge 4m+1 the previous frame's value is still shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, one pattern slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| phase_code | input | 7 | Base phase in [6:2], averaging offset in [1:0] |
| avg_bypass | input | 1 | Passes n in every slot when high at frame start |
| fine_en | input | 1 | Enables the fine thermometer output |
| pick_code | output | 5 | Phase code chosen for the current slot |
| mux_sel | output | 2 | Coarse multiplexer selects |
| flip | output | 1 | Differential-pair polarity swap |
| fine_therm | output | 4 | Thermometer code for the fine interpolator |

## Verification
The bench runs each offset over several base values and compares every slot with the expected ordering. A swapped table entry or an uneven spread would put n+1 in the wrong slot or give it the wrong number of times. The word is changed in the middle of a frame, where a design that samples on every edge would emit a broken pattern. Base 31 with a nonzero offset checks the circular increment: carrying into a sixth bit, or saturating, would give 31 where 0 is due. The bench also checks the one-edge output latency at the first frame after reset, bypass with a nonzero offset, and fine_en toggled inside a frame, where gating at the wrong edge shows up as a thermometer code one cycle off.

// File: rtl/phase_avg_pkg.sv
package phase_avg_pkg;

  // Averaging slot rule: offset k of a frame with 'slots' slots puts the
  // upper phase in slot s when the running share floor(s*k/slots) steps up.
  function automatic logic slot_hi(input int unsigned k,
                                   input int unsigned s,
                                   input int unsigned slots);
    return (((s + 1) * k) / slots) != ((s * k) / slots);
  endfunction

endpackage

// File: rtl/pas_frame_ctl.sv
module pas_frame_ctl #(
  parameter int BASE_W = 5,
  parameter int OFF_W  = 2,
  localparam int CTL_W = BASE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTL_W-1:0]  ctl_word,
  input  logic              bypass_in,
  output logic [OFF_W-1:0]  frame_cnt,
  output logic [OFF_W-1:0]  slot_q,
  output logic [BASE_W-1:0] base_q,
  output logic [OFF_W-1:0]  off_q,
  output logic              byp_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_cnt <= '0;
      slot_q    <= '0;
      base_q    <= '0;
      off_q     <= '0;
      byp_q     <= 1'b0;
    end else begin
      frame_cnt <= frame_cnt + 1'b1;
      slot_q    <= frame_cnt;
      if (frame_cnt == '0) begin
        base_q <= ctl_word[CTL_W-1:OFF_W];
        off_q  <= ctl_word[OFF_W-1:0];
        byp_q  <= bypass_in;
      end
    end
  end

endmodule

// File: rtl/pas_pick.sv
module pas_pick
  import phase_avg_pkg::*;
#(
  parameter int BASE_W = 5,
  parameter int OFF_W  = 2,
  localparam int SLOTS = 1 << OFF_W
) (
  input  logic [BASE_W-1:0] base_q,
  input  logic [OFF_W-1:0]  off_q,
  input  logic              byp_q,
  input  logic [OFF_W-1:0]  slot_q,
  output logic [BASE_W-1:0] code
);

  logic hi;

  always_comb begin
    hi   = !byp_q && slot_hi(int'(unsigned'(off_q)), int'(unsigned'(slot_q)), SLOTS);
    code = base_q + BASE_W'(hi);
  end

endmodule

// File: rtl/pas_split.sv
module pas_split #(
  parameter int BASE_W = 5,
  parameter int FINE_W = 2,
  localparam int COARSE_W = BASE_W - FINE_W,
  localparam int THERM_W  = 1 << FINE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [BASE_W-1:0]     code_in,
  input  logic                  fine_en,
  output logic [BASE_W-1:0]     pick_code,
  output logic [COARSE_W-2:0]   mux_sel,
  output logic                  flip,
  output logic [THERM_W-1:0]    therm
);

  logic [THERM_W-1:0] therm_c;

  for (genvar i = 0; i < THERM_W; i++) begin : g_therm
    assign therm_c[i] = fine_en && (code_in[FINE_W-1:0] > FINE_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pick_code <= '0;
      mux_sel   <= '0;
      flip      <= 1'b0;
      therm     <= '0;
    end else begin
      pick_code <= code_in;
      mux_sel   <= code_in[BASE_W-2:FINE_W];
      flip      <= code_in[BASE_W-1];
      therm     <= therm_c;
    end
  end

endmodule

// File: rtl/phase_avg_seq.sv
module phase_avg_seq #(
  parameter int BASE_W = 5,
  parameter int OFF_W  = 2,
  parameter int FINE_W = 2,
  localparam int CTL_W    = BASE_W + OFF_W,
  localparam int COARSE_W = BASE_W - FINE_W,
  localparam int THERM_W  = 1 << FINE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CTL_W-1:0]    phase_code,
  input  logic                avg_bypass,
  input  logic                fine_en,
  output logic [BASE_W-1:0]   pick_code,
  output logic [COARSE_W-2:0] mux_sel,
  output logic                flip,
  output logic [THERM_W-1:0]  fine_therm
);

  logic [OFF_W-1:0]  frame_cnt;
  logic [OFF_W-1:0]  slot_q;
  logic [BASE_W-1:0] base_q;
  logic [OFF_W-1:0]  off_q;
  logic              byp_q;
  logic [BASE_W-1:0] code_c;

  pas_frame_ctl #(.BASE_W(BASE_W), .OFF_W(OFF_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .ctl_word  (phase_code),
    .bypass_in (avg_bypass),
    .frame_cnt (frame_cnt),
    .slot_q    (slot_q),
    .base_q    (base_q),
    .off_q     (off_q),
    .byp_q     (byp_q)
  );

  pas_pick #(.BASE_W(BASE_W), .OFF_W(OFF_W)) u_pick (
    .base_q (base_q),
    .off_q  (off_q),
    .byp_q  (byp_q),
    .slot_q (slot_q),
    .code   (code_c)
  );

  pas_split #(.BASE_W(BASE_W), .FINE_W(FINE_W)) u_split (
    .clk       (clk),
    .rst       (rst),
    .code_in   (code_c),
    .fine_en   (fine_en),
    .pick_code (pick_code),
    .mux_sel   (mux_sel),
    .flip      (flip),
    .therm     (fine_therm)
  );

endmodule

// File: rtl/phase_avg_seq_chk.sv
module phase_avg_seq_chk #(
  parameter int BASE_W = 5,
  parameter int OFF_W  = 2,
  parameter int FINE_W = 2,
  localparam int COARSE_W = BASE_W - FINE_W,
  localparam int THERM_W  = 1 << FINE_W
) (
  input logic                clk,
  input logic                rst,
  input logic                fine_en,
  input logic [BASE_W-1:0]   pick_code,
  input logic [COARSE_W-2:0] mux_sel,
  input logic                flip,
  input logic [THERM_W-1:0]  fine_therm,
  input logic [OFF_W-1:0]    frame_cnt,
  input logic [BASE_W-1:0]   base_q
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (pick_code == '0 && fine_therm == '0 && frame_cnt == '0));

  assert_frame_advance_R12: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> frame_cnt == OFF_W'($past(frame_cnt) + 1'b1));

  assert_word_held_R2: assert property (@(posedge clk) disable iff (rst)
    (frame_cnt != '0) |=> $stable(base_q));

  assert_coarse_split_R9: assert property (@(posedge clk) disable iff (rst)
    (flip == pick_code[BASE_W-1]) && (mux_sel == pick_code[BASE_W-2:FINE_W]));

  assert_therm_count_R10: assert property (@(posedge clk) disable iff (rst)
    $past(fine_en) |-> ($countones(fine_therm) == int'(pick_code[FINE_W-1:0])));

  assert_fine_off_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(fine_en) |-> fine_therm == '0);

endmodule

bind phase_avg_seq phase_avg_seq_chk #(
  .BASE_W(BASE_W), .OFF_W(OFF_W), .FINE_W(FINE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fine_en    (fine_en),
  .pick_code  (pick_code),
  .mux_sel    (mux_sel),
  .flip       (flip),
  .fine_therm (fine_therm),
  .frame_cnt  (frame_cnt),
  .base_q     (base_q)
);

// File: tb/phase_avg_seq_test.sv
module phase_avg_seq_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] phase_code = '0;
  logic       avg_bypass = 1'b0;
  logic       fine_en = 1'b1;
  logic [4:0] pick_code;
  logic [1:0] mux_sel;
  logic       flip;
  logic [3:0] fine_therm;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [1:0] m_pos = '0, m_slot = '0, m_k = '0;
  logic [4:0] m_n = '0, m_code = '0;
  logic       m_byp = 1'b0;
  logic [3:0] m_therm = '0;

  always #2 clk = ~clk;

  phase_avg_seq uut (
    .clk(clk), .rst(rst), .phase_code(phase_code), .avg_bypass(avg_bypass),
    .fine_en(fine_en), .pick_code(pick_code), .mux_sel(mux_sel), .flip(flip),
    .fine_therm(fine_therm)
  );

  function automatic logic want_hi(input logic [1:0] k, input logic [1:0] s);
    case (k)
      2'd0: return 1'b0;          // R3
      2'd1: return s == 2'd3;     // R4
      2'd2: return s[0];          // R5
      default: return s != 2'd0;  // R6
    endcase
  endfunction

  function automatic logic [3:0] want_therm(input logic [1:0] f);
    case (f)
      2'd0: return 4'b0000;
      2'd1: return 4'b0001;
      2'd2: return 4'b0011;
      default: return 4'b0111;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    if (rst) begin
      m_pos = '0; m_slot = '0; m_n = '0; m_k = '0; m_byp = 1'b0;
      m_code = '0; m_therm = '0;
    end else begin
      m_code  = m_byp ? m_n : m_n + {4'b0, want_hi(m_k, m_slot)};
      m_therm = fine_en ? want_therm(m_code[1:0]) : 4'b0000;
      if (m_pos == 2'd0) begin
        m_n = phase_code[6:2]; m_k = phase_code[1:0]; m_byp = avg_bypass;
      end
      m_slot = m_pos;
      m_pos  = m_pos + 2'd1;
    end
    @(negedge clk);
    check(tag, {pick_code, fine_therm}, {m_code, m_therm});
    check("R9", {flip, mux_sel}, {m_code[4], m_code[3:2]});
  endtask

  task automatic frames(input string tag, input logic [4:0] n,
                        input logic [1:0] k, input int count);
    phase_code = {n, k};
    for (int i = 0; i < 4 * count; i++) tick(tag);
  endtask

  task automatic t_reset_R1;
    rst = 1'b1;
    for (int i = 0; i < 3; i++) tick("R1");
    check("R1 pick_code", pick_code, 0);
    check("R1 fine_therm", fine_therm, 0);
    rst = 1'b0;
  endtask

  task automatic t_latency_R12;
    phase_code = {5'd9, 2'd0};
    tick("R12");
    check("R12 before", pick_code, 0);
    tick("R12");
    check("R12 first", pick_code, 9);
    tick("R12"); tick("R12");
  endtask

  task automatic t_offsets;
    frames("R3", 5'd4, 2'd0, 2);
    frames("R4", 5'd10, 2'd1, 2);
    frames("R5", 5'd17, 2'd2, 2);
    frames("R6", 5'd6, 2'd3, 2);
    frames("R4", 5'd23, 2'd1, 1);
    frames("R6", 5'd14, 2'd3, 1);
  endtask

  task automatic t_explicit_R4;
    logic [4:0] seen [4];
    phase_code = {5'd12, 2'd1};
    for (int i = 0; i < 4; i++) begin
      tick("R4");
      seen[(i + 3) % 4] = pick_code;
    end
    tick("R4");
    seen[3] = pick_code;
    check("R4 slot0", seen[0], 12);
    check("R4 slot1", seen[1], 12);
    check("R4 slot2", seen[2], 12);
    check("R4 slot3", seen[3], 13);
    for (int i = 0; i < 3; i++) tick("R4");
  endtask

  task automatic t_wrap_R7;
    frames("R7", 5'd31, 2'd2, 2);
    frames("R7", 5'd31, 2'd3, 1);
  endtask

  task automatic t_midframe_R2;
    phase_code = {5'd20, 2'd1};
    tick("R2");
    phase_code = {5'd3, 2'd3};
    avg_bypass = 1'b1;
    tick("R2"); tick("R2"); tick("R2");
    phase_code = {5'd20, 2'd1};
    avg_bypass = 1'b0;
    for (int i = 0; i < 4; i++) tick("R2");
  endtask

  task automatic t_bypass_R8;
    avg_bypass = 1'b1;
    frames("R8", 5'd11, 2'd3, 2);
    frames("R8", 5'd31, 2'd2, 1);
    avg_bypass = 1'b0;
    frames("R8", 5'd0, 2'd0, 1);
  endtask

  task automatic t_fine_R11;
    phase_code = {5'd7, 2'd2};
    tick("R11");
    fine_en = 1'b0;
    tick("R11"); tick("R11");
    check("R11 gated", fine_therm, 0);
    fine_en = 1'b1;
    tick("R10"); tick("R10");
    frames("R10", 5'd27, 2'd0, 1);
    frames("R10", 5'd30, 2'd3, 1);
  endtask

  task automatic t_reset_mid_R1;
    frames("R1", 5'd21, 2'd2, 1);
    tick("R1");
    rst = 1'b1;
    tick("R1");
    check("R1 mid", {pick_code, fine_therm}, 0);
    rst = 1'b0;
    frames("R1", 5'd5, 2'd1, 2);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog: actual hung, expected completion");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    t_reset_R1();
    t_latency_R12();
    t_offsets();
    t_explicit_R4();
    t_wrap_R7();
    t_midframe_R2();
    t_bypass_R8();
    t_fine_R11();
    t_reset_mid_R1();
    done = 1;
    finish_run();
  end

endmodule